// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

This block records a stream of samples into a small on-chip memory around a single trigger event, so that a window of activity can be inspected after the fact. Samples arrive on a valid/ready stream, and a trigger input marks the event of interest. Which part of the stream is kept around that event is fixed at elaboration by the `MODE` parameter. There are three choices: only the history before the event, only the samples from the event onward, or a window that straddles the event.

When the window is complete the block raises `done` and stops taking samples. It drops `samp_ready` at the same time. This is the only back-pressure it applies. Before `done`, every sample presented with `samp_valid` is taken in the same cycle. After `done`, the upstream may hold data or discard it, because nothing more is stored. The captured window is read through a plain address port with a registered output. Address 0 always returns the oldest sample of the window. Only a reset re-arms the block. `DEPTH` must be a power of two and at least 4.

Top module: `cap_buffer`

## Requirements
- R1: A sample is accepted on a rising clock edge exactly when `samp_valid` and `samp_ready` are both 1. `samp_ready` is 1 from reset until `done` rises, and 0 from then on.
- R2: The trigger is the first accepted sample that has `trig` = 1. A cycle with `trig` = 1 and `samp_valid` = 0 triggers nothing.
- R3: With `MODE` = 0, the memory keeps the `DEPTH` accepted samples that came before the trigger sample. The trigger sample itself is not stored.
- R4: With `MODE` = 1, the memory keeps `DEPTH` accepted samples, starting with the trigger sample.
- R5: With `MODE` = 2, addresses 0 to `DEPTH`-2 hold the `DEPTH`/2-1 samples that came before the trigger, followed by the trigger sample and the `DEPTH`/2-1 samples after it.
- R6: `done` rises on the clock edge that completes the window and stays 1 until reset. Reset clears `done` and zeroes the memory. A window position that has no sample to fill it (too few samples before the trigger) reads 0.
- R7: `rd_data` shows the entry selected by `rd_addr` one clock after `rd_addr` is applied. Address 0 holds the oldest sample of the window, and addresses increase towards newer samples.
- R8: Triggers after the first one have no effect, and samples presented after `done` change no stored entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; re-arms the block |
| samp_valid | input | 1 | Sample present on `samp_data` |
| samp_ready | output | 1 | Block accepts samples (low once `done`) |
| samp_data | input | WIDTH | Sample value |
| trig | input | 1 | Trigger flag qualified by an accepted sample |
| rd_addr | input | $clog2(DEPTH) | Read address, 0 = oldest |
| rd_data | output | WIDTH | Registered read data |
| done | output | 1 | Capture window complete |

## Verification
Three copies of the block, one for each mode, receive the same random stream with random gaps in `samp_valid`. Each copy is read back against a window computed from the recorded accepted samples. The number of samples before the trigger ranges from none, through fewer than the window needs, to many more than `DEPTH`. This separates correct wrap-around of the circular pointer from the zero fill of unwritten entries. Each run also raises `trig` with `samp_valid` low before the real trigger, and raises `trig` again after the first trigger. This shows that only the first accepted trigger counts. Extra samples and triggers are sent after `done`, followed by a second readback, to show that the stored window does not change.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_POST = 2'd1,
    ST_FULL = 2'd2
  } cap_state_e;

  // Number of writes made from the trigger sample onward, per mode.
  function automatic int post_len(int mode, int depth);
    if (mode == 0)      return 0;
    else if (mode == 1) return depth;
    else                return depth / 2;
  endfunction

  // Offset between the final write pointer and the oldest window entry.
  function automatic int base_skew(int mode);
    return (mode == 2) ? 1 : 0;
  endfunction

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MODE  = 0,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          trig,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic          full
);

  localparam int  POST_N = post_len(MODE, DEPTH);
  localparam int  CW     = $clog2(DEPTH + 1);
  localparam bit  PRE_WR = (MODE != 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(POST_N > 0 ? POST_N - 1 : 0);
  localparam logic [CW-1:0] POST_LIM = CW'(POST_N);

  cap_state_e    state, state_nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    wr_en     = 1'b0;
    state_nxt = state;
    unique case (state)
      ST_ARM: begin
        if (acc) begin
          if (trig) begin
            wr_en     = (POST_N != 0);
            state_nxt = (POST_N == 0) ? ST_FULL : ST_POST;
          end else begin
            wr_en = PRE_WR;
          end
        end
      end
      ST_POST: begin
        if (acc) begin
          wr_en = 1'b1;
          if (cnt == LAST_CNT) state_nxt = ST_FULL;
        end
      end
      default: begin
        wr_en     = 1'b0;
        state_nxt = ST_FULL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ARM;
      cnt    <= '0;
      wr_ptr <= '0;
    end else begin
      state <= state_nxt;
      if (state == ST_ARM && acc && trig) cnt <= CW'(1);
      else if (state == ST_POST && acc)   cnt <= cnt + CW'(1);
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
    end
  end

  assign full = (state == ST_FULL);

  // R4
  post_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POST) |-> (cnt < POST_LIM));

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  // R1
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == $past(wr_ptr) + AW'(1)));

endmodule

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int MODE  = 0,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    base;
  logic [AW-1:0]    rd_idx;

  generate
    if (base_skew(MODE) != 0) begin : g_skew
      assign base = wr_ptr + AW'(base_skew(MODE));
    end else begin : g_direct
      assign base = wr_ptr;
    end
  endgenerate

  assign rd_idx = base + rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[wr_ptr] <= wr_data;
      rd_data <= mem[rd_idx];
    end
  end

endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
  import cap_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int MODE  = 0,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_valid,
  output logic             samp_ready,
  input  logic [WIDTH-1:0] samp_data,
  input  logic             trig,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             done
);

  logic          acc;
  logic          wr_en;
  logic [AW-1:0] wr_ptr;
  logic          full;

  assign samp_ready = ~full;
  assign acc        = samp_valid & samp_ready;
  assign done       = full;

  cap_ctrl #(.DEPTH(DEPTH), .MODE(MODE)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .trig   (trig),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .full   (full)
  );

  cap_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .MODE(MODE)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (samp_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R8
  no_write_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  // R6
  done_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(samp_valid));

endmodule

// File: tb/cap_buffer_test.sv
module cap_buffer_test;

  localparam int W  = 8;
  localparam int D  = 8;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_valid = 1'b0;
  logic trig = 1'b0;
  logic [W-1:0]  samp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [2:0]    done_v, ready_v;
  logic [3*W-1:0] rd_v;

  int checks = 0, fails = 0;
  logic [W-1:0] hist [64];
  int n_hist = 0;
  int tidx = -1;
  bit finished = 0;

  always #2 clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    cap_buffer #(.WIDTH(W), .DEPTH(D), .MODE(m)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_valid (samp_valid),
      .samp_ready (ready_v[m]),
      .samp_data  (samp_data),
      .trig       (trig),
      .rd_addr    (rd_addr),
      .rd_data    (rd_v[m*W +: W]),
      .done       (done_v[m])
    );
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(int m, int a);
    int j;
    if (m == 0)      j = tidx - D + a;
    else if (m == 1) j = tidx + a;
    else             j = tidx - (D / 2 - 1) + a;
    if (j < 0) return 0;
    return int'(hist[j]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; samp_valid = 1'b0; trig = 1'b0;
    n_hist = 0; tidx = -1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check("R6 reset done", int'(done_v[m]), 0);
      check("R1 reset ready", int'(ready_v[m]), 1);
    end
  endtask

  task automatic push(bit v, bit t);
    @(negedge clk);
    samp_valid = v;
    trig = t;
    samp_data = W'($urandom);
    if (v) begin
      if (t && tidx < 0) tidx = n_hist;
      hist[n_hist] = samp_data;
      n_hist++;
    end
  endtask

  task automatic readback(string tag);
    @(negedge clk);
    samp_valid = 1'b0; trig = 1'b0;
    for (int a = 0; a < D; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      check({"R3 ", tag}, int'(rd_v[0 +: W]), exp_val(0, a));
      check({"R4 ", tag}, int'(rd_v[W +: W]), exp_val(1, a));
      if (a < D - 1) check({"R5 R7 ", tag}, int'(rd_v[2*W +: W]), exp_val(2, a));
    end
  endtask

  task automatic run(int pre_len);
    int sent;
    do_reset();
    sent = 0;
    while (sent < pre_len) begin
      bit v;
      v = ($urandom % 4) != 0;
      push(v, 1'b0);
      if (v) sent++;
      if (sent == pre_len / 2 && !v) push(1'b0, 1'b1);
    end
    push(1'b0, 1'b1);
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check("R2 trig without valid", int'(done_v[m]), 0);
      check("R1 ready before trigger", int'(ready_v[m]), 1);
    end
    push(1'b1, 1'b1);
    sent = 0;
    while (sent < D + 3) begin
      bit v;
      v = ($urandom % 3) != 0;
      push(v, ($urandom % 2) == 1);
      if (v) sent++;
    end
    @(negedge clk);
    samp_valid = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      check("R6 done after window", int'(done_v[m]), 1);
      check("R1 ready low when done", int'(ready_v[m]), 0);
    end
    readback("window");
    for (int k = 0; k < 5; k++) push(1'b1, 1'b1);
    readback("R8 after done");
    for (int m = 0; m < 3; m++) check("R6 done held", int'(done_v[m]), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    run(0);
    run(2);
    run(5);
    run(12);
    run(20);
    run(9);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule